// File: doc/BRIEF.md
# Dual Prefetch Buffer Controller

This block is the fetch front-end of a variable-length instruction pipeline. It sits between the instruction cache and the length decoder and keeps two byte buffers of 32 bytes each. One buffer follows the straight-line path, which includes branches predicted not taken. When branch prediction reports a taken branch, the other buffer is emptied, refilled from the predicted target, and becomes the buffer that decode reads. The roles then swap for the next taken prediction.

Decode asks for between 1 and 16 bytes each cycle. The active buffer shows the oldest bytes at its head and grants the request only when it holds at least that many. It stalls decode otherwise. Fetch runs in 16-byte aligned chunks with at most one request outstanding. When a branch resolves as mispredicted, both buffers are emptied and fetch restarts at the corrected address. Any chunk still in flight from before a redirect is thrown away when it returns.

Top module: `dpf_dual_prefetch`

## Requirements
- R1: After reset, act_sel is 0 and dec_count is 0, and a fetch request for the chunk holding RESET_ADDR (default 0) is presented.
- R2: A fetch request has req_addr[3:0] equal to 0. It is presented only while the active buffer holds at most 16 bytes and no other request is outstanding, so at most one request is in flight at a time. Successive requests on one path step by 16.
- R3: dec_count never exceeds 32. With no consumption the active buffer fills to exactly 32 bytes, and requests then stop.
- R4: Bits [8i+7:8i] of dec_data hold the byte at address P+i, where P is the address of the next unconsumed byte on the current path. Bytes are consumed strictly in address order.
- R5: dec_ready is 1 exactly when dec_take <= dec_count. dec_take bytes are removed at the clock edge only when dec_ready is 1. A dec_take of 0 removes nothing.
- R6: After a redirect to address A, the first chunk adds 16 - A[3:0] bytes, and the head byte is the byte at A.
- R7: When pred_taken is 1 (and mispredict is 0), act_sel toggles at the next edge and the newly active buffer is empty. The next request fetches the chunk holding pred_target.
- R8: When mispredict is 1, both buffers are emptied at the next edge, act_sel becomes 0 and fetch restarts at fix_addr. This takes precedence over a pred_taken in the same cycle.
- R9: The data of a request accepted before or in the same cycle as a redirect never enters any buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | output | 1 | Fetch request for one 16-byte chunk |
| req_ready | input | 1 | Cache accepts the request this cycle |
| req_addr | output | 32 | Aligned chunk address |
| rsp_valid | input | 1 | Cache returns the chunk of the outstanding request |
| rsp_data | input | 128 | Chunk bytes, lowest address in bits [7:0] |
| dec_take | input | 5 | Bytes decode wants to consume this cycle (0 to 16) |
| dec_ready | output | 1 | Active buffer holds at least dec_take bytes |
| dec_data | output | 128 | Head window of the active buffer |
| dec_count | output | 6 | Bytes held by the active buffer |
| pred_taken | input | 1 | A branch is predicted taken |
| pred_target | input | 32 | Predicted target address |
| mispredict | input | 1 | A branch resolved against its prediction |
| fix_addr | input | 32 | Corrected fetch address |
| act_sel | output | 1 | Index of the buffer feeding decode |

## Verification
A slow, fixed-rate stream with decode idle shows whether the fill stops at exactly 32 bytes and whether the request stops with it. A single large take then shows that fetch resumes at the next sequential chunk. Redirects to unaligned addresses separate correct partial-chunk entry from an off-by-offset head. A mispredict issued while a request is in flight, and a prediction and a mispredict in the same cycle, separate correct stale-data dropping and priority from a design that lets old data in. A long random run mixes all take sizes (0 to 16), random cache back-pressure and latency, and frequent redirects. Against a byte-per-address memory model, it exposes any reordering, lost byte or duplicated byte in the stream decode sees.

// File: rtl/dpf_pkg.sv
package dpf_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/dpf_rst_sync.sv
module dpf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign srst_n = stage2_q;
endmodule

// File: rtl/dpf_byte_queue.sv
module dpf_byte_queue
  import dpf_pkg::*;
#(
  parameter int BUF_BYTES = 32,
  parameter int MAX_TAKE  = 16,
  parameter int CHUNK     = 16,
  localparam int BUF_W    = BUF_BYTES * BYTE_W,
  localparam int CHUNK_W  = CHUNK * BYTE_W,
  localparam int WIN_W    = MAX_TAKE * BYTE_W,
  localparam int CNT_W    = $clog2(BUF_BYTES + 1),
  localparam int TAKE_W   = $clog2(MAX_TAKE + 1),
  localparam int OFS_W    = $clog2(CHUNK)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               take_en,
  input  logic [TAKE_W-1:0]  take_n,
  input  logic               app_en,
  input  logic [CHUNK_W-1:0] app_data,
  input  logic [OFS_W-1:0]   app_skip,
  output logic [WIN_W-1:0]   head,
  output logic [CNT_W-1:0]   count
);
  logic [BUF_W-1:0] store_q;
  logic [BUF_W-1:0] store_d;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] take_eff;
  logic [CNT_W-1:0] cnt_mid;
  logic [CNT_W-1:0] app_len;
  logic [CHUNK_W-1:0] app_bytes;
  logic [BUF_W-1:0] shifted;
  logic [BUF_W-1:0] app_wide;

  // Remove consumed bytes, then place the new chunk right behind the survivors.
  always_comb begin
    take_eff  = take_en ? CNT_W'(take_n) : '0;
    cnt_mid   = cnt_q - take_eff;
    shifted   = store_q >> {take_eff, 3'b000};
    app_bytes = app_data >> {app_skip, 3'b000};
    app_len   = CNT_W'(CHUNK) - CNT_W'(app_skip);
    app_wide  = BUF_W'(app_bytes) << {cnt_mid, 3'b000};
    if (clr) begin
      cnt_d = '0;
    end else if (app_en) begin
      cnt_d = cnt_mid + app_len;
    end else begin
      cnt_d = cnt_mid;
    end
  end

  for (genvar i = 0; i < BUF_BYTES; i++) begin : g_lane
    assign store_d[i*BYTE_W +: BYTE_W] = (cnt_mid > CNT_W'(i)) ?
        shifted[i*BYTE_W +: BYTE_W] : app_wide[i*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr || take_en || app_en) begin
      cnt_q <= cnt_d;
    end
  end

  // Byte storage carries no reset; validity lives in the count.
  always_ff @(posedge clk) begin
    if (take_en || app_en) begin
      store_q <= store_d;
    end
  end

  assign head  = store_q[WIN_W-1:0];
  assign count = cnt_q;
endmodule

// File: rtl/dpf_fetch_seq.sv
module dpf_fetch_seq #(
  parameter int ADDR_W    = 32,
  parameter int BUF_BYTES = 32,
  parameter int CHUNK     = 16,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  localparam int CNT_W    = $clog2(BUF_BYTES + 1),
  localparam int OFS_W    = $clog2(CHUNK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act,
  input  logic [CNT_W-1:0]  act_count,
  input  logic              redir,
  input  logic              redir_buf,
  input  logic [ADDR_W-1:0] redir_addr,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  output logic [1:0]        app_en,
  output logic [OFS_W-1:0]  app_skip
);
  localparam logic [CNT_W-1:0] ROOM_MAX = CNT_W'(BUF_BYTES - CHUNK);

  logic [ADDR_W-1:0] next_q [2];
  logic [ADDR_W-1:0] next_d [2];
  logic [OFS_W-1:0]  skip_q [2];
  logic [OFS_W-1:0]  skip_d [2];
  logic busy_q, busy_d;
  logic stale_q, stale_d;
  logic owner_q, owner_d;
  logic fire;
  logic deliver;

  always_comb begin
    req_valid = !busy_q && (act_count <= ROOM_MAX);
    req_addr  = next_q[act];
    fire      = req_valid && req_ready;
    deliver   = busy_q && rsp_valid && !stale_q && !redir;
    app_skip  = skip_q[owner_q];
    app_en    = '0;
    app_en[owner_q] = deliver;

    for (int b = 0; b < 2; b++) begin
      next_d[b] = next_q[b];
      skip_d[b] = skip_q[b];
      if (deliver && (owner_q == 1'(b))) begin
        skip_d[b] = '0;
      end
      if (fire && (act == 1'(b))) begin
        next_d[b] = next_q[b] + ADDR_W'(CHUNK);
      end
      if (redir && (redir_buf == 1'(b))) begin
        next_d[b] = {redir_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
        skip_d[b] = redir_addr[OFS_W-1:0];
      end
    end

    owner_d = fire ? act : owner_q;
    if (fire) begin
      busy_d  = 1'b1;
      stale_d = redir;
    end else if (busy_q && rsp_valid) begin
      busy_d  = 1'b0;
      stale_d = 1'b0;
    end else begin
      busy_d  = busy_q;
      stale_d = stale_q || (redir && busy_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q[0] <= {RESET_ADDR[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
      skip_q[0] <= RESET_ADDR[OFS_W-1:0];
      next_q[1] <= '0;
      skip_q[1] <= '0;
      busy_q    <= 1'b0;
      stale_q   <= 1'b0;
      owner_q   <= 1'b0;
    end else begin
      next_q  <= next_d;
      skip_q  <= skip_d;
      busy_q  <= busy_d;
      stale_q <= stale_d;
      owner_q <= owner_d;
    end
  end
endmodule

// File: rtl/dpf_dual_prefetch.sv
module dpf_dual_prefetch
  import dpf_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUF_BYTES = 32,
  parameter int MAX_TAKE  = 16,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  localparam int CHUNK    = BUF_BYTES / 2,
  localparam int CHUNK_W  = CHUNK * BYTE_W,
  localparam int WIN_W    = MAX_TAKE * BYTE_W,
  localparam int CNT_W    = $clog2(BUF_BYTES + 1),
  localparam int TAKE_W   = $clog2(MAX_TAKE + 1),
  localparam int OFS_W    = $clog2(CHUNK)
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [ADDR_W-1:0]  req_addr,
  input  logic               rsp_valid,
  input  logic [CHUNK_W-1:0] rsp_data,
  input  logic [TAKE_W-1:0]  dec_take,
  output logic               dec_ready,
  output logic [WIN_W-1:0]   dec_data,
  output logic [CNT_W-1:0]   dec_count,
  input  logic               pred_taken,
  input  logic [ADDR_W-1:0]  pred_target,
  input  logic               mispredict,
  input  logic [ADDR_W-1:0]  fix_addr,
  output logic               act_sel
);
  logic              rst_sync_n;
  logic              act_q, act_d;
  logic              redir;
  logic              redir_buf;
  logic [ADDR_W-1:0] redir_addr;
  logic [1:0]        app_en;
  logic [OFS_W-1:0]  app_skip;
  logic [CNT_W-1:0]  cnt_b  [2];
  logic [WIN_W-1:0]  head_b [2];

  dpf_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  // Buffer select: a mispredict returns to buffer 0, a taken prediction swaps.
  always_comb begin
    redir      = mispredict || pred_taken;
    redir_buf  = mispredict ? 1'b0 : !act_q;
    redir_addr = mispredict ? fix_addr : pred_target;
    act_d      = redir ? redir_buf : act_q;
    dec_count  = cnt_b[act_q];
    dec_data   = head_b[act_q];
    dec_ready  = CNT_W'(dec_take) <= cnt_b[act_q];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      act_q <= 1'b0;
    end else if (redir) begin
      act_q <= act_d;
    end
  end

  assign act_sel = act_q;

  for (genvar b = 0; b < 2; b++) begin : g_buf
    logic clr_b;
    logic take_b;
    assign clr_b  = mispredict || (pred_taken && (redir_buf == 1'(b)));
    assign take_b = dec_ready && (act_q == 1'(b));

    dpf_byte_queue #(
      .BUF_BYTES (BUF_BYTES),
      .MAX_TAKE  (MAX_TAKE),
      .CHUNK     (CHUNK)
    ) u_queue (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .clr      (clr_b),
      .take_en  (take_b),
      .take_n   (dec_take),
      .app_en   (app_en[b]),
      .app_data (rsp_data),
      .app_skip (app_skip),
      .head     (head_b[b]),
      .count    (cnt_b[b])
    );
  end

  dpf_fetch_seq #(
    .ADDR_W     (ADDR_W),
    .BUF_BYTES  (BUF_BYTES),
    .CHUNK      (CHUNK),
    .RESET_ADDR (RESET_ADDR)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .act        (act_q),
    .act_count  (cnt_b[act_q]),
    .redir      (redir),
    .redir_buf  (redir_buf),
    .redir_addr (redir_addr),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .app_en     (app_en),
    .app_skip   (app_skip)
  );
endmodule

// File: rtl/dpf_dual_prefetch_chk.sv
module dpf_dual_prefetch_chk #(
  parameter int BUF_BYTES = 32,
  parameter int CHUNK     = 16,
  parameter int CNT_W     = 6,
  parameter int OFS_W     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [OFS_W-1:0] req_ofs,
  input logic             rsp_valid,
  input logic             dec_ready,
  input logic [CNT_W-1:0] dec_count,
  input logic             pred_taken,
  input logic             mispredict,
  input logic             act_sel
);
  p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_ofs == '0));

  p_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid);

  p_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (dec_count <= CNT_W'(BUF_BYTES - CHUNK)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_count <= CNT_W'(BUF_BYTES));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_ready && !rsp_valid && !pred_taken && !mispredict) |=> $stable(dec_count));

  p_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_taken && !mispredict) |=> ((act_sel != $past(act_sel)) && (dec_count == '0)));

  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |=> ((act_sel == 1'b0) && (dec_count == '0)));
endmodule

bind dpf_dual_prefetch dpf_dual_prefetch_chk #(
  .BUF_BYTES (BUF_BYTES),
  .CHUNK     (CHUNK),
  .CNT_W     (CNT_W),
  .OFS_W     (OFS_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_ofs    (req_addr[OFS_W-1:0]),
  .rsp_valid  (rsp_valid),
  .dec_ready  (dec_ready),
  .dec_count  (dec_count),
  .pred_taken (pred_taken),
  .mispredict (mispredict),
  .act_sel    (act_sel)
);

// File: tb/tb_dpf_dual_prefetch.sv
`timescale 1ns/1ps
module tb_dpf_dual_prefetch;
  localparam int AW = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_ready;
  logic [31:0]  req_addr;
  logic         rsp_valid;
  logic [127:0] rsp_data;
  logic [4:0]   dec_take;
  logic         dec_ready;
  logic [127:0] dec_data;
  logic [5:0]   dec_count;
  logic         pred_taken, mispredict, act_sel;
  logic [31:0]  pred_target, fix_addr;

  always #4 clk = ~clk;

  dpf_dual_prefetch dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .dec_take(dec_take), .dec_ready(dec_ready), .dec_data(dec_data), .dec_count(dec_count),
    .pred_taken(pred_taken), .pred_target(pred_target),
    .mispredict(mispredict), .fix_addr(fix_addr), .act_sel(act_sel)
  );

  int errs = 0;
  int checks = 0;
  int t_take = 0;
  bit t_pred = 0, t_mis = 0;
  logic [31:0] t_tgt = '0, t_fix = '0;
  int rdy_mode = 0;
  logic [31:0] pc = '0;
  bit exp_act = 0;
  bit pend = 0;
  logic [31:0] pend_addr = '0;
  int lat = 0;
  longint consumed = 0;

  function automatic logic [7:0] mem_b(input logic [31:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16];
  endfunction

  function automatic logic [127:0] chunk(input logic [31:0] a);
    logic [127:0] d;
    for (int i = 0; i < 16; i++) d[8*i +: 8] = mem_b(a + 32'(i));
    return d;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint got, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // One cycle: drive at the falling edge, check, then advance to the next falling edge.
  task automatic tick();
    bit ok;
    logic [7:0] g, e;
    rsp_valid = 1'b0;
    if (pend) begin
      if (lat <= 1) begin
        rsp_valid = 1'b1;
        rsp_data  = chunk(pend_addr);
        pend      = 0;
      end else begin
        lat--;
      end
    end
    req_ready   = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? ($urandom % 4 != 0) : 1'b0;
    dec_take    = 5'(t_take);
    pred_taken  = t_pred;
    pred_target = t_tgt;
    mispredict  = t_mis;
    fix_addr    = t_fix;
    #1;
    chk(act_sel == exp_act, "R7 act_sel", act_sel, exp_act);
    chk(dec_ready == (t_take <= int'(dec_count)), "R5 dec_ready", dec_ready, t_take <= int'(dec_count));
    if (req_valid && req_ready) begin
      chk(!pend, "R2 one outstanding", pend, 0);
      chk(req_addr[3:0] == 4'h0, "R2 aligned", req_addr, {req_addr[31:4], 4'h0});
      pend = 1;
      pend_addr = req_addr;
      lat = 2 + int'($urandom % 2);
    end
    if (dec_ready && t_take != 0) begin
      ok = 1; g = '0; e = '0;
      for (int i = 0; i < t_take; i++) begin
        if (ok && dec_data[8*i +: 8] !== mem_b(pc + 32'(i))) begin
          ok = 0; g = dec_data[8*i +: 8]; e = mem_b(pc + 32'(i));
        end
      end
      chk(ok, "R4 byte order", g, e);
      pc = pc + 32'(t_take);
      consumed += t_take;
    end
    if (t_mis) begin
      pc = t_fix; exp_act = 0;
    end else if (t_pred) begin
      pc = t_tgt; exp_act = ~exp_act;
    end
    @(posedge clk);
    @(negedge clk);
    t_pred = 0;
    t_mis = 0;
  endtask

  task automatic idle(input int n);
    t_take = 0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wait_fill();
    for (int i = 0; i < 12; i++) begin
      if (dec_count != 0) break;
      tick();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R4 watchdog: got %0d expected %0d", 200000, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_ready = 0; rsp_valid = 0; rsp_data = '0;
    dec_take = 0; pred_taken = 0; pred_target = '0; mispredict = 0; fix_addr = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    rdy_mode = 2;
    idle(3);
    // R1 reset state
    chk(act_sel == 1'b0, "R1 act_sel", act_sel, 0);
    chk(dec_count == 0, "R1 dec_count", dec_count, 0);
    chk(req_valid && req_addr == 32'h0, "R1 first request", req_addr, 0);

    // R3 fill with no consumption
    rdy_mode = 0;
    idle(25);
    chk(dec_count == 6'd32, "R3 fill level", dec_count, 32);
    chk(!req_valid, "R3 request stops when full", req_valid, 0);

    // R2 consume one chunk, next sequential chunk requested
    t_take = 16; tick(); t_take = 0;
    chk(dec_count == 6'd16, "R5 count after take", dec_count, 16);
    chk(req_valid && req_addr == 32'h20, "R2 sequential step", req_addr, 32'h20);
    idle(8);

    // R8 mispredict to unaligned address, R6 partial entry
    t_mis = 1; t_fix = 32'h1003; tick();
    chk(dec_count == 0 && act_sel == 0, "R8 flush", dec_count, 0);
    chk(req_valid && req_addr == 32'h1000, "R8 restart address", req_addr, 32'h1000);
    wait_fill();
    chk(dec_count == 6'd13, "R6 partial count", dec_count, 13);
    chk(dec_data[7:0] == mem_b(32'h1003), "R6 head byte", dec_data[7:0], mem_b(32'h1003));
    idle(8);
    chk(dec_count == 6'd29, "R3 partial fill level", dec_count, 29);

    // R7 taken prediction switches buffers
    t_pred = 1; t_tgt = 32'h2007; tick();
    chk(act_sel == 1'b1 && dec_count == 0, "R7 switch", {act_sel, dec_count}, 7'h40);
    chk(req_valid && req_addr == 32'h2000, "R7 target fetch", req_addr, 32'h2000);
    wait_fill();
    chk(dec_count == 6'd9, "R6 target partial count", dec_count, 9);
    t_take = 9; tick(); idle(8);

    // R9 redirect while a request is in flight
    t_mis = 1; t_fix = 32'h3000; tick();
    tick();
    chk(pend, "R9 request in flight", pend, 1);
    t_mis = 1; t_fix = 32'h4005; tick();
    wait_fill();
    chk(dec_count == 6'd11, "R9 stale chunk dropped", dec_count, 11);
    chk(dec_data[7:0] == mem_b(32'h4005), "R9 head byte", dec_data[7:0], mem_b(32'h4005));
    idle(8);

    // R8 precedence over simultaneous prediction
    t_pred = 1; t_tgt = 32'h5000; t_mis = 1; t_fix = 32'h6002; tick();
    chk(act_sel == 1'b0 && dec_count == 0, "R8 precedence", act_sel, 0);
    wait_fill();
    chk(dec_count == 6'd14 && dec_data[7:0] == mem_b(32'h6002), "R8 restart data", dec_count, 14);
    t_take = 16; tick(); t_take = 0;
    chk(dec_count == 6'd14, "R5 refused take keeps bytes", dec_count, 14);

    // Random phase
    rdy_mode = 1;
    consumed = 0;
    for (int n = 0; n < 4000; n++) begin
      t_take = int'($urandom % 17);
      t_pred = ($urandom % 40 == 0);
      t_tgt  = $urandom % 65536;
      t_mis  = ($urandom % 60 == 0);
      t_fix  = $urandom % 65536;
      tick();
    end
    chk(consumed > 2000, "R4 stream progress", consumed, 2000);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule